// File: doc/BRIEF.md
# Stereo Oversampling FIR Interpolator

This block raises the sample rate of a stereo PCM stream by a fixed oversampling factor. Each accepted input pair (left and right, 24 bits each) is written into a per-channel history memory. The block then produces `OSR` output pairs, one for each polyphase branch. Every output is a dot product of the most recent input samples with one branch of a user-loaded coefficient table. A single 35x35-bit signed multiplier feeding a 70-bit accumulator does all the work. It runs at a fixed fast clock and handles the left channel first, then the right. The tap count of a branch is limited by the clock cycles that one output period allows.

The host fills the coefficient table through a write port with a valid/ready handshake. That port is ready only while no dot product is being formed. A rewrite therefore never splits an output: it takes effect from the next output pair. Results are rounded to nearest and clamped to a 28-bit output, which leaves headroom for later digital attenuation.

Top module: `fir_interp`

## Requirements
- R1: After reset, `in_ready` = 1, `cw_ready` = 1 and `out_valid` = 0, and every history entry is zero.
- R2: An input pair is taken only when `in_valid` and `in_ready` are both high. `in_ready` then stays low until all `OSR` output pairs of that input have been accepted.
- R3: Each accepted input yields `OSR` output pairs in phase order 0 to `OSR`-1. Phase p of a channel is round_sat(sum over k<T of coef[k*OSR+p] * x[n-k]). Here x[n] is the newest sample, the coefficient address holds k in its upper bits and p in its low log2(`OSR`) bits, and samples older than the first input count as zero.
- R4: Both channels use the same coefficients, but each channel keeps its own history, so left data never reaches the right output.
- R5: T = min(`coef_len`, floor((CLK_HZ/OUT_RATE_HZ - 6)/2), COEF_DEPTH/OSR), which is 61 with the default parameters. `coef_len` is sampled when each output pair starts.
- R6: With T = 0, both outputs are exactly zero.
- R7: Rounding is floor((acc + 2^27) / 2^28), so a result exactly halfway rounds upward. A coefficient of 2^32 is unity gain, and the output is the input scaled by 2^4 (28-bit output from 24-bit input).
- R8: A rounded result above 2^27-1 is output as 2^27-1, and one below -2^27 is output as -2^27. The output never wraps.
- R9: `cw_ready` is high only while idle or while an output pair is presented, never during a dot product. A write accepted during an input's processing does not change any output already under way.
- R10: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_l` and `out_r` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock for the MAC engine |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Engine idle, can take a pair |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Consumer takes the output pair |
| out_l | output | 28 | Left oversampled result, signed |
| out_r | output | 28 | Right oversampled result, signed |
| cw_valid | input | 1 | Coefficient write request |
| cw_ready | output | 1 | Coefficient write can be accepted |
| cw_addr | input | 10 | Coefficient index {k, phase} |
| cw_data | input | 35 | Coefficient value, signed, 2^32 = 1.0 |
| coef_len | input | 8 | Requested taps per phase |

## Verification
The main function is tried with three input patterns. Unequal ramps on the two channels with eight taps show any crossing between channel histories and any phase-order error. A long run at two taps followed by a request for 100 taps fills the history deeply enough that the cycle-budget cap of 61 taps can be told apart from using the requested length. Single-tap unit-size and full-scale inputs isolate the rounding direction at exact halves and the clamping at both rails. A coefficient rewrite issued while the third tap of phase 0 is being fetched shows whether the update leaks into the output being computed.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAC,
    ST_DRAIN,
    ST_DONE,
    ST_OUT
  } fir_state_e;
endpackage

// File: rtl/fir_coef_ram.sv
module fir_coef_ram #(
  parameter int W     = 35,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fir_hist_ram.sv
module fir_hist_ram #(
  parameter int W     = 24,
  parameter int DEPTH = 128,
  parameter int NCH   = 2,
  localparam int AW   = $clog2(DEPTH)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [NCH-1:0][W-1:0]    wdata,
  input  logic [AW-1:0]            raddr,
  output logic [NCH-1:0][W-1:0]    rdata
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        rdata[c] <= '0;
      end else begin
        if (we) mem[waddr] <= wdata[c];
        rdata[c] <= mem[raddr];
      end
    end
  end
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int A_W   = 35,
  parameter int ACC_W = 70
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [A_W-1:0]   a,
  input  logic signed [A_W-1:0]   b,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [ACC_W-1:0] ax, bx, prod;

  assign ax   = {{(ACC_W-A_W){a[A_W-1]}}, a};
  assign bx   = {{(ACC_W-A_W){b[A_W-1]}}, b};
  assign prod = ax * bx;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + prod;
  end
endmodule

// File: rtl/fir_interp.sv
module fir_interp
  import fir_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int COEF_W      = 35,
  parameter int ACC_W       = 70,
  parameter int OUT_W       = 28,
  parameter int COEF_DEPTH  = 1024,
  parameter int OSR         = 8,
  parameter int CLK_HZ      = 49152000,
  parameter int OUT_RATE_HZ = 384000,
  parameter int COEF_FRAC   = 32,
  localparam int HIST_DEPTH = COEF_DEPTH / OSR,
  localparam int HA_W       = $clog2(HIST_DEPTH),
  localparam int PH_W       = $clog2(OSR),
  localparam int CA_W       = HA_W + PH_W,
  localparam int LEN_W      = $clog2(HIST_DEPTH + 1)
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_l,
  input  logic signed [DATA_W-1:0] in_r,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [OUT_W-1:0]  out_l,
  output logic signed [OUT_W-1:0]  out_r,
  input  logic                     cw_valid,
  output logic                     cw_ready,
  input  logic [CA_W-1:0]          cw_addr,
  input  logic signed [COEF_W-1:0] cw_data,
  input  logic [LEN_W-1:0]         coef_len
);
  localparam int CYC_PER_OUT = CLK_HZ / OUT_RATE_HZ;
  localparam int OVERHEAD    = 6;
  localparam int BUDGET      = (CYC_PER_OUT - OVERHEAD) / 2;
  localparam int TAP_CAP     = (BUDGET < HIST_DEPTH) ? BUDGET : HIST_DEPTH;
  localparam int SHIFT       = COEF_FRAC - (OUT_W - DATA_W);
  localparam logic signed [ACC_W-1:0] BIAS    = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] OUT_MAX = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -(ACC_W'(1) <<< (OUT_W - 1));

  // Round half upward, then clamp to the output range.
  function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] q;
    q = (a + BIAS) >>> SHIFT;
    if (q > OUT_MAX)      round_sat = OUT_MAX[OUT_W-1:0];
    else if (q < OUT_MIN) round_sat = OUT_MIN[OUT_W-1:0];
    else                  round_sat = q[OUT_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] cap_taps(input logic [LEN_W-1:0] req);
    cap_taps = (req > LEN_W'(TAP_CAP)) ? LEN_W'(TAP_CAP) : req;
  endfunction

  fir_state_e              st;
  logic [PH_W-1:0]         phase;
  logic                    ch;
  logic [LEN_W-1:0]        k, taps, eff_taps;
  logic [HA_W-1:0]         newest, hist_waddr, hist_raddr;
  logic [CA_W-1:0]         coef_raddr;
  logic [1:0][DATA_W-1:0]  hist_wdata, hist_rdata;
  logic signed [DATA_W-1:0] samp;
  logic signed [COEF_W-1:0] samp_ext, coef_rd;
  logic signed [ACC_W-1:0] acc;
  logic                    rd_vld;

  // Named internal events, also used by the checker.
  logic in_fire, out_fire, cw_fire, next_out, last_tap;
  logic tap_issue, mac_busy, mac_clr;

  assign in_ready   = (st == ST_IDLE);
  assign out_valid  = (st == ST_OUT);
  assign cw_ready   = (st == ST_IDLE) || (st == ST_OUT);
  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign cw_fire    = cw_valid && cw_ready;
  assign next_out   = in_fire || (out_fire && (phase != PH_W'(OSR - 1)));
  assign tap_issue  = (st == ST_MAC);
  assign last_tap   = (k == taps - LEN_W'(1));
  assign mac_busy   = (st == ST_MAC) || (st == ST_DRAIN) || (st == ST_DONE);
  assign mac_clr    = next_out || ((st == ST_DONE) && !ch);
  assign eff_taps   = cap_taps(coef_len);

  assign hist_waddr = newest + HA_W'(1);
  assign hist_wdata = {in_r, in_l};
  assign hist_raddr = newest - k[HA_W-1:0];
  assign coef_raddr = {k[HA_W-1:0], phase};
  assign samp       = ch ? hist_rdata[1] : hist_rdata[0];
  assign samp_ext   = {{(COEF_W-DATA_W){samp[DATA_W-1]}}, samp};

  fir_coef_ram #(.W(COEF_W), .DEPTH(COEF_DEPTH)) u_coef (
    .clk(clk), .we(cw_fire), .waddr(cw_addr), .wdata(cw_data),
    .raddr(coef_raddr), .rdata(coef_rd)
  );

  fir_hist_ram #(.W(DATA_W), .DEPTH(HIST_DEPTH), .NCH(2)) u_hist (
    .clk(clk), .rst_n(rst_n), .we(in_fire), .waddr(hist_waddr),
    .wdata(hist_wdata), .raddr(hist_raddr), .rdata(hist_rdata)
  );

  fir_mac #(.A_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(rd_vld),
    .a(coef_rd), .b(samp_ext), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      phase  <= '0;
      ch     <= 1'b0;
      k      <= '0;
      taps   <= '0;
      newest <= '0;
      rd_vld <= 1'b0;
      out_l  <= '0;
      out_r  <= '0;
    end else begin
      rd_vld <= tap_issue;
      if (in_fire) begin
        newest <= hist_waddr;
        phase  <= '0;
      end
      if (out_fire) phase <= phase + PH_W'(1);
      if (next_out) begin
        ch   <= 1'b0;
        k    <= '0;
        taps <= eff_taps;
        st   <= (eff_taps == '0) ? ST_DRAIN : ST_MAC;
      end else begin
        unique case (st)
          ST_MAC: begin
            k <= k + LEN_W'(1);
            if (last_tap) st <= ST_DRAIN;
          end
          ST_DRAIN: st <= ST_DONE;
          ST_DONE: begin
            if (!ch) begin
              out_l <= round_sat(acc);
              ch    <= 1'b1;
              k     <= '0;
              st    <= (taps == '0) ? ST_DRAIN : ST_MAC;
            end else begin
              out_r <= round_sat(acc);
              st    <= ST_OUT;
            end
          end
          ST_OUT:  if (out_fire) st <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/fir_interp_chk.sv
module fir_interp_chk #(
  parameter int OUT_W = 28,
  parameter int LEN_W = 8,
  parameter int CAP   = 61
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_l,
  input logic [OUT_W-1:0] out_r,
  input logic             cw_fire,
  input logic             mac_busy,
  input logic             tap_issue,
  input logic [LEN_W-1:0] tap_idx
);
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R2

  AST_NO_TAP_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    tap_issue |-> !out_valid && !in_ready); // R3

  AST_TAP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tap_issue |-> (tap_idx < LEN_W'(CAP))); // R5

  AST_COEF_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    mac_busy |-> !cw_fire); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_l) && $stable(out_r)); // R10
endmodule

bind fir_interp fir_interp_chk #(.OUT_W(OUT_W), .LEN_W(LEN_W), .CAP(TAP_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_l(out_l), .out_r(out_r),
  .cw_fire(cw_fire), .mac_busy(mac_busy), .tap_issue(tap_issue), .tap_idx(k)
);

// File: tb/fir_interp_test.sv
module fir_interp_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 8;
  localparam int TAP_BUDGET = (49152000 / 384000 - 6) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic out_valid, out_ready = 1'b1;
  logic signed [27:0] out_l, out_r;
  logic cw_valid = 1'b0, cw_ready;
  logic [9:0] cw_addr = '0;
  logic signed [34:0] cw_data = '0;
  logic [7:0] coef_len = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic signed [34:0] cm [1024];
  logic signed [23:0] hl[$], hr[$];
  logic signed [27:0] exp_l[$], exp_r[$];
  string exp_tag[$];
  int cur_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_interp uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_ready(out_ready),
    .out_l(out_l), .out_r(out_r), .cw_valid(cw_valid), .cw_ready(cw_ready),
    .cw_addr(cw_addr), .cw_data(cw_data), .coef_len(coef_len)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic signed [27:0] model_out(input int p, input bit right);
    logic signed [69:0] acc, a, b, q;
    int t;
    t = cur_len;
    if (t > TAP_BUDGET) t = TAP_BUDGET;
    if (t > 1024 / OSR) t = 1024 / OSR;
    acc = '0;
    for (int k = 0; k < t; k++) begin
      a = cm[k*OSR + p];
      b = '0;
      if (right) begin
        if (k < hr.size()) b = hr[k];
      end else if (k < hl.size()) b = hl[k];
      acc = acc + a * b;
    end
    q = acc + (70'sd1 <<< 27);
    q = q >>> 28;
    if (q > 70'sd134217727)  return 28'sh7FFFFFF;
    if (q < -70'sd134217728) return 28'sh8000000;
    return q[27:0];
  endfunction

  // Driver: push the expected outputs, then hand the pair over.
  task automatic send_sample(input int l, input int r, input string tag);
    hl.push_front(24'(l));
    hr.push_front(24'(r));
    if (hl.size() > 128) begin
      void'(hl.pop_back());
      void'(hr.pop_back());
    end
    for (int p = 0; p < OSR; p++) begin
      exp_l.push_back(model_out(p, 1'b0));
      exp_r.push_back(model_out(p, 1'b1));
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_l = 24'(l);
    in_r = 24'(r);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R2", "in_ready after accept", longint'(in_ready), 0);
  endtask

  task automatic write_coef(input int idx, input logic signed [34:0] val);
    @(negedge clk);
    cw_valid = 1'b1;
    cw_addr  = 10'(idx);
    cw_data  = val;
    while (!cw_ready) @(negedge clk);
    @(negedge clk);
    cw_valid = 1'b0;
    cm[idx] = val;
  endtask

  task automatic set_len(input int n);
    @(negedge clk);
    coef_len = 8'(n);
    cur_len  = n;
  endtask

  task automatic wait_drain();
    while (exp_l.size() != 0 || !in_ready) @(negedge clk);
  endtask

  // Monitor: compare each taken output pair with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (out_valid && out_ready) begin
        if (exp_l.size() == 0) begin
          check(1'b0, "R2", "unexpected output", longint'(out_l), 0);
        end else begin
          logic signed [27:0] el, er;
          string tg;
          el = exp_l.pop_front();
          er = exp_r.pop_front();
          tg = exp_tag.pop_front();
          check(out_l == el, tg, "left", longint'(out_l), longint'(el));
          check(out_r == er, tg, "right", longint'(out_r), longint'(er));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic signed [27:0] hold_l, hold_r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1,  "R1", "in_ready",  longint'(in_ready), 1);
    check(cw_ready == 1'b1,  "R1", "cw_ready",  longint'(cw_ready), 1);
    check(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);

    for (int j = 0; j < 1024; j++)
      write_coef(j, 35'(((j * 37 + 11) % 201 - 100) * (1 <<< 22)));

    // R3 / R4: distinct ramps on both channels, eight taps per phase
    set_len(8);
    for (int i = 0; i < 12; i++)
      send_sample((i * 100003) % 4000000 - 2000000,
                  1500000 - (i * 77771) % 3000000, "R3_R4");
    wait_drain();

    // R6: zero taps gives zero output
    set_len(0);
    send_sample(5000000, -5000000, "R6");
    wait_drain();

    // R5: deep history, then request more taps than the cycle budget allows
    set_len(2);
    for (int i = 0; i < 64; i++)
      send_sample(300000 + i * 1111, -200000 - i * 2222, "R5_fill");
    wait_drain();
    set_len(100);
    send_sample(123456, -654321, "R5");
    send_sample(-777777, 888888, "R5");
    wait_drain();

    // R9: rewrite a phase-0 tap while phase 0 is being computed
    set_len(8);
    send_sample(1000000, -1000000, "R9_old");
    check(!cw_ready, "R9", "cw_ready during compute", longint'(cw_ready), 0);
    write_coef(16, 35'sd3000000000);
    wait_drain();
    send_sample(-250000, 250000, "R9_new");
    wait_drain();

    // R10: output held under backpressure
    @(negedge clk);
    out_ready = 1'b0;
    send_sample(400000, -400000, "R10");
    while (!out_valid) @(negedge clk);
    hold_l = out_l;
    hold_r = out_r;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R10", "out_valid held", longint'(out_valid), 1);
    check(out_l == hold_l, "R10", "out_l held", longint'(out_l), longint'(hold_l));
    check(out_r == hold_r, "R10", "out_r held", longint'(out_r), longint'(hold_r));
    out_ready = 1'b1;
    wait_drain();

    // R7: half-way rounding with a single tap of gain 1/2 in output units
    set_len(1);
    for (int p = 0; p < OSR; p++) write_coef(p, 35'sd134217728);
    send_sample(1, -1, "R7 expect 1/0");
    wait_drain();
    send_sample(3, -3, "R7 expect 2/-1");
    wait_drain();

    // R8: saturation at both rails
    for (int p = 0; p < OSR; p++) write_coef(p, 35'sd12884901888);
    send_sample(8388607, -8388608, "R8 expect 134217727/-134217728");
    wait_drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule